// File: doc/BRIEF.md
# Dual-Result Serial Frame Generator

This block forms the digital output stage of a two-converter, simultaneous-sampling front end. When the active-low select line falls, it captures two 12-bit results, one from each converter. It also captures the channel-select level and the range level. It then shifts 16-bit frames out on two data lines, MSB first, one bit for each falling edge of the serial clock. Line A starts with converter A's frame and line B starts with converter B's frame. If the select line stays low for another 16 clock periods, each line continues with the other converter's frame. When no transfer is running, both lines are disabled through a separate output-enable signal.

The whole block runs on one system clock. The serial clock, the select line, the range level and the channel level are each passed through a two-stage synchronizer, and edges are detected on the synchronized copies. As a result, an output updates a few system-clock cycles after the edge that caused it. Each serial clock phase must last at least four system-clock periods. The results are parallel levels from the conversion stub and have no handshake. They must be stable from the select fall until three system-clock cycles after it. The serial clock paces the transfer, so there is no back-pressure.

Top module: `dual_frame_tx`

## Requirements
- R1: While reset is active and after reset, `dout_en` is 0 and both data lines are 0.
- R2: A falling edge of `cs_n` sets `dout_en` to 1 and places the frame's bit 15, which is always 0, on both lines.
- R3: Frame layout, MSB first: bit 15 = 0, bit 14 = range level captured at the select fall, bit 13 = channel level captured at the select fall, bit 12 = source id (0 = converter A, 1 = converter B), bits 11..0 = the result.
- R4: After the k-th falling edge of `sclk` (k = 1..15), each line carries bit 15-k of its first frame. Line A's first frame has source id 0 and line B's first frame has source id 1.
- R5: After falling edge k = 16..31, each line carries bit 31-k of the other converter's frame, with that frame's source id.
- R6: The 32nd falling edge clears `dout_en` even if `cs_n` is still low. Further `sclk` edges leave `dout_en` and both lines at 0.
- R7: A rising edge of `cs_n` clears `dout_en` and both lines at any point in a transfer.
- R8: A range level of 0 at the select fall gives straight binary coding. A level of 1 gives two's complement coding, which is the binary result with bit 11 inverted.
- R9: The range level is sampled again at the 8th `sclk` falling edge. If it differs from the level captured at the select fall, every result bit sent from that edge on uses the other coding. Bit 14 still reports the level captured at the select fall.
- R10: Changes to `res_a` and `res_b` after capture do not change any bit of the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| cs_n | input | 1 | Active-low select; its fall starts a transfer |
| range_sel | input | 1 | Range and coding level |
| chan_sel | input | 1 | Channel-select level reported in the status bits |
| res_a | input | RES_W | Converter A result |
| res_b | input | RES_W | Converter B result |
| dout_a | output | 1 | Serial data line A |
| dout_b | output | 1 | Serial data line B |
| dout_en | output | 1 | Output enable; 0 models high impedance |

## Verification
The bench uses the default RES_W of 12, which gives 16-bit frames and a 32-edge transfer. At this size the 8th-edge coding switch falls between the two result MSBs: bit 11 of the first frame goes out at edge 4 and bit 11 of the chained frame at edge 20. So both the original coding and the switched coding can be seen in a single transfer. The bench checks every bit position on both lines for four input patterns, including all-ones, half-scale and single-LSB results. It also runs an early select release in the middle of the first frame.

// File: rtl/dft_pkg.sv
package dft_pkg;
  // source-id encoding carried in the status bits
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;
  // number of bits ahead of the result in a frame
  localparam int unsigned LEAD_BITS = 4;
  // falling-edge index at which the coding level is sampled again
  localparam int unsigned FLIP_EDGE = 8;
endpackage

// File: rtl/dft_sync.sv
module dft_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= INIT[i];
        s2 <= INIT[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/dft_lane.sv
module dft_lane #(
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned XFER  = 2 * FRAME_W,
  localparam int unsigned CNT_W = $clog2(XFER + 1),
  localparam int unsigned IDX_W = $clog2(XFER)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [FRAME_W-1:0] own_frame,
  input  logic [FRAME_W-1:0] other_frame,
  output logic               bit_o
);
  logic [XFER-1:0]  chain;
  logic [CNT_W-1:0] idx;

  assign chain = {own_frame, other_frame};
  assign idx   = CNT_W'(XFER - 1) - cnt;

  always_comb begin
    bit_o = 1'b0;
    if (active && (cnt < CNT_W'(XFER)))
      bit_o = chain[idx[IDX_W-1:0]];
  end

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active && $stable(cnt)) |-> $stable(bit_o));
endmodule

// File: rtl/dual_frame_tx.sv
module dual_frame_tx #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             range_sel,
  input  logic             chan_sel,
  input  logic [RES_W-1:0] res_a,
  input  logic [RES_W-1:0] res_b,
  output logic             dout_a,
  output logic             dout_b,
  output logic             dout_en
);
  import dft_pkg::*;

  localparam int unsigned FRAME_W = RES_W + LEAD_BITS;
  localparam int unsigned XFER    = 2 * FRAME_W;
  localparam int unsigned CNT_W   = $clog2(XFER + 1);

  // synchronized copies: {range, chan, cs_n, sclk}
  logic [3:0] sync_q;
  dft_sync #(.W(4), .INIT(4'b0011)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({range_sel, chan_sel, cs_n, sclk}),
    .q(sync_q)
  );

  logic sclk_s, cs_s, chan_s, rng_s;
  assign sclk_s = sync_q[0];
  assign cs_s   = sync_q[1];
  assign chan_s = sync_q[2];
  assign rng_s  = sync_q[3];

  logic sclk_d, cs_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  logic sclk_fall, cs_fall, cs_rise;
  assign sclk_fall = sclk_d & ~sclk_s;
  assign cs_fall   = cs_d & ~cs_s;
  assign cs_rise   = ~cs_d & cs_s;

  // transfer state
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [RES_W-1:0] lat [2];
  logic             lat_rng, lat_ch, coding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      lat[0]  <= '0;
      lat[1]  <= '0;
      lat_rng <= 1'b0;
      lat_ch  <= 1'b0;
      coding  <= 1'b0;
    end else if (cs_fall) begin
      active  <= 1'b1;
      cnt     <= '0;
      lat[0]  <= res_a;
      lat[1]  <= res_b;
      lat_rng <= rng_s;
      lat_ch  <= chan_s;
      coding  <= rng_s;
    end else if (cs_rise) begin
      active <= 1'b0;
    end else if (active && sclk_fall) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(XFER - 1))
        active <= 1'b0;
      // a level that differs from the captured one selects the other coding,
      // which equals the level now present
      if (cnt == CNT_W'(FLIP_EDGE - 1))
        coding <= rng_s;
    end
  end

  // frames and lanes
  logic [FRAME_W-1:0] frm [2];
  logic [1:0]         lane_bit;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic [RES_W-1:0] coded;
    assign coded  = coding ? {~lat[i][RES_W-1], lat[i][RES_W-2:0]} : lat[i];
    assign frm[i] = {1'b0, lat_rng, lat_ch, (i == 0) ? SRC_A : SRC_B, coded};

    dft_lane #(.FRAME_W(FRAME_W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .active(active), .cnt(cnt),
      .own_frame(frm[i]), .other_frame(frm[1-i]),
      .bit_o(lane_bit[i])
    );
  end

  assign dout_a  = lane_bit[0];
  assign dout_b  = lane_bit[1];
  assign dout_en = active;

  // R2
  start_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (dout_en && !dout_a && !dout_b));
  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !dout_en);
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(XFER));
  // R6
  end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(cs_rise) || ($past(cnt) == CNT_W'(XFER - 1))));
  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active) |-> ($stable(lat[0]) && $stable(lat[1]) && $stable(lat_rng)));
endmodule

// File: tb/dual_frame_tx_bench.sv
module dual_frame_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  logic range_sel = 1'b0;
  logic chan_sel = 1'b0;
  logic [11:0] res_a = '0;
  logic [11:0] res_b = '0;
  logic dout_a, dout_b, dout_en;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_frame_tx u_dual_frame_tx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .range_sel(range_sel), .chan_sel(chan_sel),
    .res_a(res_a), .res_b(res_b),
    .dout_a(dout_a), .dout_b(dout_b), .dout_en(dout_en)
  );

  // {res_a, res_b, range at select fall, channel, range at 8th edge}
  localparam logic [26:0] VEC [0:3] = '{
    {12'hA5C, 12'h3F0, 1'b0, 1'b0, 1'b0},
    {12'h800, 12'h7FF, 1'b1, 1'b1, 1'b1},
    {12'hFFF, 12'h001, 1'b0, 1'b1, 1'b1},
    {12'h123, 12'hABC, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input int lane, input int k, input logic [26:0] v);
    logic [11:0] ra, rb, r;
    logic rg, ch, r8, cod, id;
    logic [15:0] w;
    int pos;
    {ra, rb, rg, ch, r8} = v;
    id  = (k < 16) ? logic'(lane) : logic'(1 - lane);
    pos = (k < 16) ? 15 - k : 31 - k;
    cod = (k >= 8) ? r8 : rg;
    r   = id ? rb : ra;
    w   = {1'b0, rg, ch, id, cod ? {~r[11], r[10:0]} : r};
    return w[pos];
  endfunction

  task automatic run_vec(input logic [26:0] v);
    logic [11:0] ra, rb;
    logic rg, ch, r8;
    {ra, rb, rg, ch, r8} = v;
    res_a = ra; res_b = rb; range_sel = rg; chan_sel = ch;
    #40 cs_n = 1'b0;
    #30;
    chk("R2 enable", dout_en, 1'b1);
    chk("R2 lead A", dout_a, exp_bit(0, 0, v));
    chk("R2 lead B", dout_b, exp_bit(1, 0, v));
    for (int k = 1; k < 32; k++) begin
      string tag;
      sclk = 1'b0;
      #25;
      if (k < 4) tag = "R3 status";
      else if (k == 4) tag = "R8 first MSB";
      else if (k == 20) tag = "R9 chained MSB";
      else if (k < 16) tag = "R4 R10 first frame";
      else tag = "R5 chained frame";
      chk(tag, dout_a, exp_bit(0, k, v));
      chk(tag, dout_b, exp_bit(1, k, v));
      if (k == 2) begin
        res_a = ~ra; res_b = ~rb;
      end
      if (k == 5) range_sel = r8;
      sclk = 1'b1;
      #25;
    end
    sclk = 1'b0;
    #25;
    chk("R6 end enable", dout_en, 1'b0);
    chk("R6 end line", dout_a | dout_b, 1'b0);
    sclk = 1'b1;
    #25;
    for (int e = 0; e < 2; e++) begin
      sclk = 1'b0; #25;
      chk("R6 idle low", dout_en | dout_a | dout_b, 1'b0);
      sclk = 1'b1; #25;
    end
    cs_n = 1'b1;
    #50;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #22;
    chk("R1 enable in reset", dout_en, 1'b0);
    chk("R1 lines in reset", dout_a | dout_b, 1'b0);
    rst_n = 1'b1;
    #30;
    chk("R1 enable after reset", dout_en, 1'b0);

    for (int i = 0; i < 4; i++) run_vec(VEC[i]);

    // early release of the select line in the middle of frame one
    res_a = 12'hFFF; res_b = 12'hFFF; range_sel = 1'b0; chan_sel = 1'b1;
    #40 cs_n = 1'b0;
    #30;
    chk("R2 enable", dout_en, 1'b1);
    for (int k = 1; k <= 5; k++) begin
      sclk = 1'b0; #25; sclk = 1'b1; #25;
    end
    chk("R4 before release", dout_a, 1'b1);
    cs_n = 1'b1;
    #30;
    chk("R7 enable cleared", dout_en, 1'b0);
    chk("R7 lines cleared", dout_a | dout_b, 1'b0);
    sclk = 1'b0; #25;
    chk("R7 stays idle", dout_en, 1'b0);
    sclk = 1'b1; #25;

    // a new transfer after the release starts cleanly
    run_vec(VEC[1]);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule